// File: doc/BRIEF.md
# Fault Campaign Sequencer

This block steps one fault-injection experiment through a fixed order of phases. A start pulse takes it out of idle into a set-up phase, where it tells the logger to begin recording. It then waits on three separate go conditions from the system under test. The first launches the workload. The second launches the injector together with its trigger process. The third turns the trigger on. The trigger stays on for a programmable number of clock cycles. When that time has passed, the sequencer enters a finish phase that tells every process to stop, and it then returns to idle with a done pulse.

While the workload, the injector or the trigger is active, two independent error inputs are watched. Each error leads to its own error phase. That phase records which error occurred and proceeds to finish on the next cycle. A 2-bit status output reports how the last experiment ended.

All action outputs are single-cycle strobes, except the trigger enable, which is a level. The logger, the workload and the injector are outside the block and appear only as these strobes and the condition inputs.

Top module: `fic_seq`

## Requirements
- R1: While rst_n is low on a rising edge, the sequencer returns to idle, all strobes and trig_en_o are low, and status_o is 00.
- R2: A high start_i in idle leads, one edge later, to the set-up phase and a single-cycle log_start_o pulse. start_i has no effect outside idle.
- R3: go_app_i is acted on only in the set-up phase and gives one app_start_o pulse. go_inj_i is acted on only in the workload phase and gives one inj_start_o pulse. go_trig_i is acted on only in the injector phase and raises trig_en_o. Each go input is ignored in every other phase.
- R4: trig_en_o stays high for exactly max(N,1) consecutive cycles. N is trig_len_i sampled on the edge that enters the trigger phase, so N=0 behaves as 1 and later changes to trig_len_i have no effect.
- R5: When the trigger time ends, kill_o pulses for one cycle with trig_en_o low. done_o pulses for one cycle on the next cycle, with the block back in idle.
- R6: In the workload, injector or trigger phase, a high err_a_i leads on the next edge to error phase A. That edge drops trig_en_o and sets status_o to 01. kill_o follows one cycle later.
- R7: In the same phases, err_b_i alone leads to error phase B, drops trig_en_o and sets status_o to 10. kill_o follows one cycle later.
- R8: err_a_i wins over err_b_i, and any error wins over a go condition presented in the same cycle.
- R9: err_a_i and err_b_i are ignored in idle and in the set-up phase. They leave status_o unchanged and do not cause kill_o.
- R10: status_o is cleared to 00 on the edge that leaves idle. It otherwise holds its value, including after done_o, until the next start.
- R11: At most one of log_start_o, app_start_o, inj_start_o, kill_o and done_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches an experiment from idle |
| trig_len_i | input | CNT_W | Trigger-on duration in cycles |
| go_app_i | input | 1 | Condition to start the workload |
| go_inj_i | input | 1 | Condition to start injector and trigger |
| go_trig_i | input | 1 | Condition to switch the trigger on |
| err_a_i | input | 1 | First error condition |
| err_b_i | input | 1 | Second error condition |
| log_start_o | output | 1 | Pulse: begin logging |
| app_start_o | output | 1 | Pulse: start workload |
| inj_start_o | output | 1 | Pulse: start injector and trigger processes |
| trig_en_o | output | 1 | Level: trigger enabled |
| kill_o | output | 1 | Pulse: terminate all processes |
| done_o | output | 1 | Pulse: experiment exited |
| status_o | output | 2 | 00 ok, 01 error A, 10 error B |

## Verification
A wrong phase register shows up at the ports on the edge after the bad transition. It gives a strobe that is missing, repeated or out of order, or a kill_o that comes early. A trigger counter that is off by one changes the length of the trig_en_o window, so the bench counts that window cycle by cycle for several lengths, including zero. A wrong error priority or gating shows in status_o, and kill_o then shows it one cycle later. The bench presents errors and go conditions together, and in the phases that must ignore them.

// File: rtl/fic_pkg.sv
// Package: shared phase and status encodings for the campaign sequencer.
// Assumes: all users agree on these encodings; no other state exists.
package fic_pkg;

    // Campaign phases.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_RUN  = 3'd2,
        ST_ARM  = 3'd3,
        ST_TRIG = 3'd4,
        ST_ERRA = 3'd5,
        ST_ERRB = 3'd6,
        ST_FIN  = 3'd7
    } camp_st_e;

    // Final status codes reported at the port.
    typedef enum logic [1:0] {
        CS_OK   = 2'b00,
        CS_ERRA = 2'b01,
        CS_ERRB = 2'b10
    } camp_stat_e;

    // Number of entry strobes (set-up, workload, injector, finish, exit).
    localparam int NUM_PULSE = 5;

    // Phases in which the error inputs are observed.
    function automatic logic err_watch(input camp_st_e st);
        return (st == ST_RUN) || (st == ST_ARM) || (st == ST_TRIG);
    endfunction

endpackage

// File: rtl/fic_seq_fsm.sv
// Module: phase register and next-phase logic of the campaign.
// Assumes: inputs are synchronous to clk; expire_i is valid only in ST_TRIG.
// Errors outrank go conditions, and error A outranks error B.
module fic_seq_fsm
    import fic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     go_app_i,
    input  logic     go_inj_i,
    input  logic     go_trig_i,
    input  logic     err_a_i,
    input  logic     err_b_i,
    input  logic     expire_i,
    output camp_st_e st_q,
    output camp_st_e st_d
);

    logic err_hit;

    // Error qualifier: an error counts only in watched phases.
    always_comb begin
        err_hit = err_watch(st_q) && (err_a_i || err_b_i);
    end

    // Next-phase selection.
    always_comb begin
        st_d = st_q;
        if (err_hit) begin
            st_d = err_a_i ? ST_ERRA : ST_ERRB;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_i)   st_d = ST_INIT;
                ST_INIT: if (go_app_i)  st_d = ST_RUN;
                ST_RUN:  if (go_inj_i)  st_d = ST_ARM;
                ST_ARM:  if (go_trig_i) st_d = ST_TRIG;
                ST_TRIG: if (expire_i)  st_d = ST_FIN;
                ST_ERRA: st_d = ST_FIN;
                ST_ERRB: st_d = ST_FIN;
                ST_FIN:  st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/fic_dwell_timer.sv
// Module: down-counter that measures the trigger-on window.
// Assumes: load_i is a single-cycle pulse on the edge entering the window.
// A length of zero is treated as one cycle.
module fic_dwell_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Load value, with a zero length clamped to one.
    always_comb begin
        load_val = (len_i == '0) ? ONE : len_i;
    end

    // Expiry: the last cycle of the window.
    always_comb begin
        expire_o = run_i && (cnt_q <= ONE);
    end

    // Counter: load on entry, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load_i)           cnt_q <= load_val;
        else if (run_i && !expire_o) cnt_q <= cnt_q - ONE;
    end

endmodule

// File: rtl/fic_strobe_gen.sv
// Module: registered output stage. It pulses one strobe per phase entry,
// holds the trigger enable level and keeps the final status.
// Assumes: st_d is the phase that st_q takes on the next edge.
module fic_strobe_gen
    import fic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  camp_st_e             st_q,
    input  camp_st_e             st_d,
    output logic [NUM_PULSE-1:0] pulse_o,
    output logic                 trig_en_o,
    output logic [1:0]           status_o
);

    // Phase whose entry fires each strobe bit.
    localparam camp_st_e PULSE_ST [NUM_PULSE] =
        '{ST_INIT, ST_RUN, ST_ARM, ST_FIN, ST_IDLE};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PULSE; gi++) begin : g_pulse
            // Entry strobe for one phase.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse_o[gi] <= 1'b0;
                else        pulse_o[gi] <= (st_d == PULSE_ST[gi]) &&
                                           (st_q != PULSE_ST[gi]);
            end
        end
    endgenerate

    // Trigger enable level, high throughout the trigger phase.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_en_o <= 1'b0;
        else        trig_en_o <= (st_d == ST_TRIG);
    end

    // Final status: cleared on launch, set on error entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_o <= CS_OK;
        else if (st_q == ST_IDLE && st_d == ST_INIT)
            status_o <= CS_OK;
        else if (st_d == ST_ERRA && st_q != ST_ERRA)
            status_o <= CS_ERRA;
        else if (st_d == ST_ERRB && st_q != ST_ERRB)
            status_o <= CS_ERRB;
    end

endmodule

// File: rtl/fic_seq.sv
// Module: top of the fault campaign sequencer.
// Assumes: the condition and error inputs are synchronous to clk, and
// the attached processes act on strobes that are one cycle wide.
module fic_seq
    import fic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] trig_len_i,
    input  logic             go_app_i,
    input  logic             go_inj_i,
    input  logic             go_trig_i,
    input  logic             err_a_i,
    input  logic             err_b_i,
    output logic             log_start_o,
    output logic             app_start_o,
    output logic             inj_start_o,
    output logic             trig_en_o,
    output logic             kill_o,
    output logic             done_o,
    output logic [1:0]       status_o
);

    camp_st_e             st_q;
    camp_st_e             st_d;
    logic                 expire;
    logic                 tmr_load;
    logic                 tmr_run;
    logic [NUM_PULSE-1:0] pulse;

    // Timer controls derived from the phase transition.
    always_comb begin
        tmr_load = (st_d == ST_TRIG) && (st_q != ST_TRIG);
        tmr_run  = (st_q == ST_TRIG);
    end

    fic_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .go_app_i  (go_app_i),
        .go_inj_i  (go_inj_i),
        .go_trig_i (go_trig_i),
        .err_a_i   (err_a_i),
        .err_b_i   (err_b_i),
        .expire_i  (expire),
        .st_q      (st_q),
        .st_d      (st_d)
    );

    fic_dwell_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .run_i    (tmr_run),
        .len_i    (trig_len_i),
        .expire_o (expire)
    );

    fic_strobe_gen u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_q      (st_q),
        .st_d      (st_d),
        .pulse_o   (pulse),
        .trig_en_o (trig_en_o),
        .status_o  (status_o)
    );

    // Map the strobe vector onto named outputs.
    always_comb begin
        log_start_o = pulse[0];
        app_start_o = pulse[1];
        inj_start_o = pulse[2];
        kill_o      = pulse[3];
        done_o      = pulse[4];
    end

endmodule

// File: rtl/fic_seq_chk.sv
// Module: assertion checker bound to fic_seq.
// Assumes: st_q is the top's phase register.
module fic_seq_chk
    import fic_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       err_a_i,
    input logic       err_b_i,
    input logic       log_start_o,
    input logic       app_start_o,
    input logic       inj_start_o,
    input logic       trig_en_o,
    input logic       kill_o,
    input logic       done_o,
    input logic [1:0] status_o,
    input camp_st_e   st_q
);

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({log_start_o, app_start_o, inj_start_o, kill_o, done_o}));

    a_r2_start_logs: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st_q == ST_IDLE) |=> log_start_o);

    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> !log_start_o);

    a_r5_done_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |=> done_o && !trig_en_o);

    a_r6_err_a_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (err_watch(st_q) && err_a_i) |=> (!trig_en_o && status_o == 2'b01));

    a_r7_err_b_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (err_watch(st_q) && err_b_i && !err_a_i) |=>
            (!trig_en_o && status_o == 2'b10));

    a_r9_init_ignores_err: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_INIT && (err_a_i || err_b_i)) |=> $stable(status_o));

    a_r10_clear_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(log_start_o) |-> (status_o == 2'b00));

endmodule

bind fic_seq fic_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .err_a_i     (err_a_i),
    .err_b_i     (err_b_i),
    .log_start_o (log_start_o),
    .app_start_o (app_start_o),
    .inj_start_o (inj_start_o),
    .trig_en_o   (trig_en_o),
    .kill_o      (kill_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .st_q        (st_q)
);

// File: tb/fic_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for fic_seq. Each task drives its own stimulus
// and checks its own results. Inputs change and outputs are sampled at the
// falling edge.
module fic_seq_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] trig_len_i = '0;
    logic             go_app_i = 1'b0;
    logic             go_inj_i = 1'b0;
    logic             go_trig_i = 1'b0;
    logic             err_a_i = 1'b0;
    logic             err_b_i = 1'b0;
    logic             log_start_o, app_start_o, inj_start_o;
    logic             trig_en_o, kill_o, done_o;
    logic [1:0]       status_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fic_seq #(.CNT_W(CNT_W)) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .trig_len_i (trig_len_i), .go_app_i (go_app_i),
        .go_inj_i (go_inj_i), .go_trig_i (go_trig_i),
        .err_a_i (err_a_i), .err_b_i (err_b_i),
        .log_start_o (log_start_o), .app_start_o (app_start_o),
        .inj_start_o (inj_start_o), .trig_en_o (trig_en_o),
        .kill_o (kill_o), .done_o (done_o), .status_o (status_o)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: wait for the next falling edge, then check R11.
    task automatic cyc();
        @(negedge clk);
        chk("R11", "strobe count",
            int'(log_start_o) + int'(app_start_o) + int'(inj_start_o) +
            int'(kill_o) + int'(done_o) > 1 ? 1 : 0, 0);
    endtask

    task automatic launch(input int len);
        trig_len_i = CNT_W'(len);
        start_i = 1'b1; cyc(); start_i = 1'b0;
    endtask

    task automatic to_run();  go_app_i = 1'b1;  cyc(); go_app_i = 1'b0;  endtask
    task automatic to_arm();  go_inj_i = 1'b1;  cyc(); go_inj_i = 1'b0;  endtask
    task automatic to_trig(); go_trig_i = 1'b1; cyc(); go_trig_i = 1'b0; endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "strobes", {log_start_o, app_start_o, inj_start_o,
                              kill_o, done_o, trig_en_o}, 0);
        chk("R1", "status", status_o, 0);
    endtask

    task automatic t_nominal(input int len);
        int on_cnt;
        int exp_len;
        exp_len = (len == 0) ? 1 : len;
        launch(len);
        chk("R2", "log_start", log_start_o, 1);
        chk("R10", "status cleared", status_o, 0);
        cyc();
        chk("R2", "log_start single", log_start_o, 0);
        to_run();
        chk("R3", "app_start", app_start_o, 1);
        to_arm();
        chk("R3", "inj_start", inj_start_o, 1);
        to_trig();
        chk("R3", "trig_en", trig_en_o, 1);
        trig_len_i = CNT_W'(99);
        on_cnt = 1;
        for (int i = 0; i < 200; i++) begin
            cyc();
            if (!trig_en_o) break;
            on_cnt++;
        end
        chk("R4", "trigger window", on_cnt, exp_len);
        chk("R5", "kill", kill_o, 1);
        chk("R5", "done early", done_o, 0);
        cyc();
        chk("R5", "kill single", kill_o, 0);
        chk("R5", "done", done_o, 1);
        chk("R10", "status ok", status_o, 0);
        cyc();
        chk("R5", "done single", done_o, 0);
    endtask

    task automatic t_err_a_run();
        launch(3);
        to_run();
        err_a_i = 1'b1; go_inj_i = 1'b1;
        cyc();
        err_a_i = 1'b0; go_inj_i = 1'b0;
        chk("R8", "error beats go_inj", inj_start_o, 0);
        chk("R6", "status A", status_o, 1);
        chk("R6", "kill not yet", kill_o, 0);
        cyc();
        chk("R6", "kill", kill_o, 1);
        cyc();
        chk("R5", "done after error", done_o, 1);
        chk("R10", "status held", status_o, 1);
    endtask

    task automatic t_ignored_zero();
        err_a_i = 1'b1; go_app_i = 1'b1;
        cyc();
        err_a_i = 1'b0; go_app_i = 1'b0;
        chk("R3", "go_app in idle", app_start_o, 0);
        chk("R9", "idle error kill", kill_o, 0);
        chk("R9", "idle error status", status_o, 1);
        launch(0);
        chk("R10", "status cleared", status_o, 0);
        err_a_i = 1'b1; err_b_i = 1'b1; go_inj_i = 1'b1; go_trig_i = 1'b1;
        cyc();
        err_a_i = 1'b0; err_b_i = 1'b0; go_inj_i = 1'b0; go_trig_i = 1'b0;
        chk("R9", "init error status", status_o, 0);
        chk("R9", "init error kill", kill_o, 0);
        chk("R3", "go_inj in init", inj_start_o, 0);
        chk("R3", "go_trig in init", trig_en_o, 0);
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
        chk("R2", "start while busy", log_start_o, 0);
        to_run();
        to_arm();
        to_trig();
        chk("R4", "zero length on", trig_en_o, 1);
        cyc();
        chk("R4", "zero length off", trig_en_o, 0);
        chk("R4", "zero length kill", kill_o, 1);
        cyc();
        chk("R5", "done", done_o, 1);
    endtask

    task automatic t_err_b_trig();
        launch(8);
        to_run();
        to_arm();
        to_trig();
        cyc();
        chk("R4", "still on", trig_en_o, 1);
        err_b_i = 1'b1;
        cyc();
        err_b_i = 1'b0;
        chk("R7", "trig dropped", trig_en_o, 0);
        chk("R7", "status B", status_o, 2);
        cyc();
        chk("R7", "kill", kill_o, 1);
        cyc();
        chk("R5", "done", done_o, 1);
    endtask

    task automatic t_both_arm();
        launch(5);
        to_run();
        to_arm();
        err_a_i = 1'b1; err_b_i = 1'b1; go_trig_i = 1'b1;
        cyc();
        err_a_i = 1'b0; err_b_i = 1'b0; go_trig_i = 1'b0;
        chk("R8", "error beats go_trig", trig_en_o, 0);
        chk("R8", "A beats B", status_o, 1);
        cyc();
        chk("R6", "kill", kill_o, 1);
        cyc();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_nominal(4);
        t_err_a_run();
        t_ignored_zero();
        t_err_b_trig();
        t_both_arm();
        t_nominal(1);
        t_nominal(7);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule